// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block checks every load, store and instruction fetch of a processor before it reaches the bus. Software programs a small set of regions. Each region has a base address, a power-of-two size, read and write permissions for privileged and unprivileged code, and a no-execute attribute. Each access arrives with its address, its kind and a privilege flag. The block answers with one of three results: allow, a memory-management fault or a bus fault. On a memory-management fault it also records the faulting address.

Requests enter on a valid/ready handshake, and results leave on a second one. The result register holds one entry. A request is taken when `req_valid` and `req_ready` are both high on a clock edge. Its result appears on `rsp_valid`/`rsp_code` after that edge and stays unchanged until `rsp_ready` is high at an edge. `req_ready` is high whenever the result register is empty or is being drained in the same cycle. The upper 512 MiB of the address space is a system window that bypasses all region checks. The configuration port, the fault clear and the fault record are plain level signals.

Top module: `mpu_checker`

## Requirements
- R1: The parameter `NUM_REGIONS` (8 or 16) sets the region count. A write with `cfg_we` high takes effect at the next edge, and `cfg_kind` selects the target. Kind 0 loads the base register of region `cfg_idx`. Kind 1 loads its attribute register. Kind 2 loads the global control register. Kind 3 is ignored.
- R2: Attribute bits [6:1] hold k, the log2 of the region size in bytes. Values below 5 act as 5 (32 B) and values above 32 act as 32 (the whole 4 GiB). A region covers an address when address bits [31:k] equal base bits [31:k].
- R3: Base bits below k may be written non-zero. They are stored but play no part in matching.
- R4: In a matching region, privileged accesses use attribute bit 7 (read) and bit 8 (write). Unprivileged accesses use bit 9 (read) and bit 10 (write). `req_type` is 0 for read, 1 for write and 2 for fetch; 3 is treated as read.
- R5: A fetch needs the read permission of its privilege level, and attribute bit 11 (no-execute) must be clear. A denied fetch is a memory-management fault even when reads are permitted.
- R6: When several enabled regions match, the one with the highest index decides the result.
- R7: Attribute bit 0 enables a region. A disabled region never matches.
- R8: Control bit 0 enables checking, and control bit 1 is the privileged-default-map bit. With checking off, every access outside the system window is allowed. With checking on, an access that matches no region is allowed only if it is privileged and bit 1 is set; otherwise it is a memory-management fault.
- R9: Addresses 0xE000_0000 to 0xFFFF_FFFF bypass the regions and the enable bit. Unprivileged accesses there return a bus fault (code 2). Privileged accesses there are allowed (code 0).
- R10: The control space at 0xE000_E000 to 0xE000_EFFF is reachable only by privileged accesses. An unprivileged access there returns a bus fault, never a memory-management fault.
- R11: A memory-management fault (code 1) sets `flt_valid` and records the address in `flt_addr`, but only when the flag was clear or `flt_clr` is high in that cycle. While the flag is set, the record stays unchanged. `flt_clr` on its own clears the flag at the next edge. Bus faults are not recorded.
- R12: A taken request shows its result one cycle later. While `rsp_valid` is high and `rsp_ready` is low, the result holds and `req_ready` is low.
- R13: After reset all regions and the control register are zero, and `rsp_valid`, `flt_valid` and `flt_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 base, 1 attribute, 2 control |
| cfg_idx | input | $clog2(NUM_REGIONS) | Region index for base and attribute writes |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Checker can take a request |
| req_addr | input | 32 | Access address |
| req_type | input | 2 | 0 read, 1 write, 2 fetch |
| req_priv | input | 1 | 1 for a privileged access |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_code | output | 2 | 0 allow, 1 memory-management fault, 2 bus fault |
| flt_clr | input | 1 | Clear the fault record flag |
| flt_valid | output | 1 | Fault record holds an address |
| flt_addr | output | 32 | Recorded faulting address |

## Verification
A corrupted base, size mask or permission bit only becomes visible when an access lands in the affected region. It then shows as a wrong `rsp_code` one cycle after the request is taken. The stimulus therefore aims many addresses near region edges. A wrong priority choice shows only where regions overlap, so the directed tests deliberately stack two regions. Errors in the fault record show on `flt_valid` and `flt_addr` in the same cycle as the faulting result. They can stay hidden until a second fault arrives or until a clear is given, so both sequences are driven.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  localparam int ADDR_W = 32;

  // access kinds as seen on req_type
  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  // configuration targets
  localparam logic [1:0] CFG_BASE = 2'd0;
  localparam logic [1:0] CFG_ATTR = 2'd1;
  localparam logic [1:0] CFG_CTRL = 2'd2;

  // system window: top three address bits all set
  localparam logic [2:0] SYS_TOP = 3'b111;
  // control space page inside the system window
  localparam logic [19:0] CTL_PAGE = 20'hE000E;

  localparam int MIN_LOG2 = 5;
  localparam int MAX_LOG2 = 32;

  typedef enum logic [1:0] {
    RSP_OK     = 2'd0,
    RSP_MEMFLT = 2'd1,
    RSP_BUSFLT = 2'd2
  } rsp_t;

  // attribute register layout, bit 11 down to bit 0
  typedef struct packed {
    logic       nx;
    logic       usr_wr;
    logic       usr_rd;
    logic       prv_wr;
    logic       prv_rd;
    logic [5:0] size_log2;
    logic       en;
  } rgn_attr_t;

  localparam int ATTR_W = $bits(rgn_attr_t);

endpackage

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = $clog2(NUM_REGIONS)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [1:0]                         cfg_kind,
  input  logic [IDX_W-1:0]                   cfg_idx,
  input  logic [ADDR_W-1:0]                  cfg_wdata,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_o,
  output rgn_attr_t [NUM_REGIONS-1:0]        attr_o,
  output logic                               chk_en_o,
  output logic                               dflt_map_o
);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    logic hit_idx;
    assign hit_idx = cfg_we && (cfg_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_o[g] <= '0;
        attr_o[g] <= '0;
      end else if (hit_idx) begin
        if (cfg_kind == CFG_BASE) base_o[g] <= cfg_wdata;
        if (cfg_kind == CFG_ATTR) attr_o[g] <= rgn_attr_t'(cfg_wdata[ATTR_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_en_o   <= 1'b0;
      dflt_map_o <= 1'b0;
    end else if (cfg_we && cfg_kind == CFG_CTRL) begin
      chk_en_o   <= cfg_wdata[0];
      dflt_map_o <= cfg_wdata[1];
    end
  end

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_pkg::*;
(
  input  logic [ADDR_W-1:0] base_i,
  input  rgn_attr_t         attr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        type_i,
  input  logic              priv_i,
  output logic              hit_o,
  output logic              permit_o
);

  logic [5:0]        k_eff;
  logic [ADDR_W-1:0] cmp_mask;
  logic              can_rd;
  logic              can_wr;

  always_comb begin
    k_eff = attr_i.size_log2;
    if (k_eff < 6'(MIN_LOG2)) k_eff = 6'(MIN_LOG2);
    if (k_eff > 6'(MAX_LOG2)) k_eff = 6'(MAX_LOG2);
  end

  // bits at or above k take part in the compare; base bits below k are don't-care
  always_comb begin
    for (int i = 0; i < ADDR_W; i++) begin
      cmp_mask[i] = (6'(i) >= k_eff);
    end
  end

  assign hit_o  = attr_i.en && (((addr_i ^ base_i) & cmp_mask) == '0);
  assign can_rd = priv_i ? attr_i.prv_rd : attr_i.usr_rd;
  assign can_wr = priv_i ? attr_i.prv_wr : attr_i.usr_wr;

  always_comb begin
    case (type_i)
      ACC_WR:  permit_o = can_wr;
      ACC_EX:  permit_o = can_rd && !attr_i.nx;
      default: permit_o = can_rd;
    endcase
  end

endmodule

// File: rtl/mpu_prio_sel.sv
module mpu_prio_sel #(
  parameter int NUM_REGIONS = 8
) (
  input  logic [NUM_REGIONS-1:0] hit_i,
  input  logic [NUM_REGIONS-1:0] permit_i,
  output logic                   any_hit_o,
  output logic                   permit_o
);

  // walk upward so the highest matching index is the last to write
  always_comb begin
    any_hit_o = 1'b0;
    permit_o  = 1'b0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (hit_i[r]) begin
        any_hit_o = 1'b1;
        permit_o  = permit_i[r];
      end
    end
  end

endmodule

// File: rtl/mpu_checker.sv
module mpu_checker
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = $clog2(NUM_REGIONS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic [1:0]        req_type,
  input  logic              req_priv,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_code,
  input  logic              flt_clr,
  output logic              flt_valid,
  output logic [31:0]       flt_addr
);

  logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_q;
  rgn_attr_t [NUM_REGIONS-1:0]        attr_q;
  logic                               chk_en;
  logic                               dflt_map;
  logic [NUM_REGIONS-1:0]             rgn_hit;
  logic [NUM_REGIONS-1:0]             rgn_permit;
  logic                               any_hit;
  logic                               sel_permit;
  logic                               in_sys;
  logic                               in_ctl;
  logic                               take;
  rsp_t                               verdict;
  rsp_t                               code_q;

  mpu_region_bank #(.NUM_REGIONS(NUM_REGIONS)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_kind   (cfg_kind),
    .cfg_idx    (cfg_idx),
    .cfg_wdata  (cfg_wdata),
    .base_o     (base_q),
    .attr_o     (attr_q),
    .chk_en_o   (chk_en),
    .dflt_map_o (dflt_map)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    mpu_region_match u_match (
      .base_i   (base_q[g]),
      .attr_i   (attr_q[g]),
      .addr_i   (req_addr),
      .type_i   (req_type),
      .priv_i   (req_priv),
      .hit_o    (rgn_hit[g]),
      .permit_o (rgn_permit[g])
    );
  end

  mpu_prio_sel #(.NUM_REGIONS(NUM_REGIONS)) u_prio (
    .hit_i     (rgn_hit),
    .permit_i  (rgn_permit),
    .any_hit_o (any_hit),
    .permit_o  (sel_permit)
  );

  assign in_sys = (req_addr[31:29] == SYS_TOP);
  assign in_ctl = (req_addr[31:12] == CTL_PAGE);

  always_comb begin
    if (in_ctl) begin
      verdict = req_priv ? RSP_OK : RSP_BUSFLT;
    end else if (in_sys) begin
      verdict = req_priv ? RSP_OK : RSP_BUSFLT;
    end else if (!chk_en) begin
      verdict = RSP_OK;
    end else if (any_hit) begin
      verdict = sel_permit ? RSP_OK : RSP_MEMFLT;
    end else begin
      verdict = (req_priv && dflt_map) ? RSP_OK : RSP_MEMFLT;
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      code_q    <= RSP_OK;
    end else if (take) begin
      rsp_valid <= 1'b1;
      code_q    <= verdict;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_code = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      flt_addr  <= '0;
    end else if (take && verdict == RSP_MEMFLT && (!flt_valid || flt_clr)) begin
      flt_valid <= 1'b1;
      flt_addr  <= req_addr;
    end else if (flt_clr) begin
      flt_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mpu_checker_sva.sv
module mpu_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        req_priv,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [1:0]  rsp_code,
  input logic        flt_clr,
  input logic        flt_valid,
  input logic [31:0] flt_addr
);

  AST_SYS_UNPRIV_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[31:29] == 3'b111 && !req_priv) |=> (rsp_code == 2'd2)); // R9

  AST_SYS_PRIV_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[31:29] == 3'b111 && req_priv) |=> (rsp_code == 2'd0)); // R9

  AST_CTL_UNPRIV_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[31:12] == 20'hE000E && !req_priv) |=> (rsp_code == 2'd2)); // R10

  AST_TAKE_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R12

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code))); // R12

  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R12

  AST_FLT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_clr) |=> (flt_valid && $stable(flt_addr))); // R11

  AST_FLT_ON_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_code != 2'd1 || flt_valid)); // R11

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code != 2'd3)); // R12

endmodule

bind mpu_checker mpu_checker_sva u_sva (.*);

// File: tb/mpu_checker_tb.sv
module mpu_checker_tb;

  localparam int NREG = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = 2'd0;
  logic [2:0]  cfg_idx = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = 32'd0;
  logic [1:0]  req_type = 2'd0;
  logic        req_priv = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_code;
  logic        flt_clr = 1'b0;
  logic        flt_valid;
  logic [31:0] flt_addr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // bench-side model state
  logic [31:0] m_base [NREG];
  logic [11:0] m_attr [NREG];
  logic        m_en = 1'b0;
  logic        m_pdm = 1'b0;
  logic        m_fv = 1'b0;
  logic [31:0] m_fa = 32'd0;

  always #10 clk = ~clk;

  mpu_checker #(.NUM_REGIONS(NREG)) u_dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int eff_k(input logic [5:0] f);
    int k = int'(f);
    if (k < 5) k = 5;
    if (k > 32) k = 32;
    return k;
  endfunction

  function automatic logic [1:0] model(input logic [31:0] a, input logic [1:0] t, input logic p);
    logic hit = 1'b0;
    logic ok = 1'b0;
    if (a >= 32'hE000_0000) return p ? 2'd0 : 2'd2;
    if (!m_en) return 2'd0;
    for (int r = 0; r < NREG; r++) begin
      if (m_attr[r][0]) begin
        int k = eff_k(m_attr[r][6:1]);
        if ((64'(a) >> k) == (64'(m_base[r]) >> k)) begin
          logic rd = p ? m_attr[r][7] : m_attr[r][9];
          logic wr = p ? m_attr[r][8] : m_attr[r][10];
          hit = 1'b1;
          if (t == 2'd1) ok = wr;
          else if (t == 2'd2) ok = rd && !m_attr[r][11];
          else ok = rd;
        end
      end
    end
    if (hit) return ok ? 2'd0 : 2'd1;
    return (p && m_pdm) ? 2'd0 : 2'd1;
  endfunction

  function automatic logic [31:0] mk_attr(input bit en, input int k, input bit prd, input bit pwr,
                                          input bit urd, input bit uwr, input bit nx);
    logic [31:0] v = 32'd0;
    v[0] = en; v[6:1] = 6'(k); v[7] = prd; v[8] = pwr; v[9] = urd; v[10] = uwr; v[11] = nx;
    return v;
  endfunction

  task automatic cfg(input logic [1:0] kind, input logic [2:0] idx, input logic [31:0] d);
    cfg_we = 1'b1; cfg_kind = kind; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (kind)
      2'd0: m_base[idx] = d;
      2'd1: m_attr[idx] = d[11:0];
      2'd2: begin m_en = d[0]; m_pdm = d[1]; end
      default: ;
    endcase
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] t, input logic p,
                        input logic clr, input string tag);
    logic [1:0] e = model(a, t, p);
    req_valid = 1'b1; req_addr = a; req_type = t; req_priv = p; flt_clr = clr;
    @(negedge clk);
    req_valid = 1'b0; flt_clr = 1'b0;
    if (e == 2'd1 && (!m_fv || clr)) begin m_fv = 1'b1; m_fa = a; end
    else if (clr) m_fv = 1'b0;
    check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " code"}, 32'(rsp_code), 32'(e));
    check({tag, " flt_valid R11"}, 32'(flt_valid), 32'(m_fv));
    if (m_fv) check({tag, " flt_addr R11"}, flt_addr, m_fa);
  endtask

  task automatic clear_flag();
    flt_clr = 1'b1;
    @(negedge clk);
    flt_clr = 1'b0;
    m_fv = 1'b0;
    check("R11 clear", 32'(flt_valid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < NREG; r++) begin m_base[r] = '0; m_attr[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    check("R13 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R13 flt_valid", 32'(flt_valid), 32'd0);
    check("R13 flt_addr", flt_addr, 32'd0);
    check("R13 req_ready", 32'(req_ready), 32'd1);
    access(32'h1234_5678, 2'd1, 1'b0, 1'b0, "R13 R8 disabled allows");

    // R9 / R10 system window
    access(32'hE000_1000, 2'd0, 1'b0, 1'b0, "R9 unpriv window");
    access(32'hF000_0000, 2'd1, 1'b1, 1'b0, "R9 priv window");
    access(32'hE000_E010, 2'd0, 1'b0, 1'b0, "R10 unpriv ctl space");
    access(32'hE000_EFFC, 2'd1, 1'b1, 1'b0, "R10 priv ctl space");

    // R4 basic region, 32 KiB at 0x2000_0000
    cfg(2'd0, 3'd0, 32'h2000_0000);
    cfg(2'd1, 3'd0, mk_attr(1, 15, 1, 1, 1, 0, 0));
    cfg(2'd2, 3'd0, 32'd1);
    access(32'h2000_0100, 2'd1, 1'b0, 1'b0, "R4 user write denied");
    access(32'h2000_0104, 2'd0, 1'b0, 1'b0, "R4 user read ok");
    access(32'h2000_7FFC, 2'd1, 1'b1, 1'b0, "R4 priv write ok");
    access(32'h2000_8000, 2'd0, 1'b0, 1'b0, "R8 R11 miss keeps first record");
    access(32'hE000_E000, 2'd0, 1'b0, 1'b0, "R10 R11 bus fault not recorded");

    // R3 / R6 misaligned base, overlapping higher region
    cfg(2'd0, 3'd1, 32'h2000_1234);
    cfg(2'd1, 3'd1, mk_attr(1, 12, 1, 1, 1, 1, 0));
    clear_flag();
    access(32'h2000_1000, 2'd1, 1'b0, 1'b0, "R3 R6 low edge higher region wins");
    access(32'h2000_1FFF, 2'd1, 1'b0, 1'b0, "R3 high edge");
    access(32'h2000_2000, 2'd1, 1'b0, 1'b0, "R6 falls to region 0");

    // R5 no-execute
    cfg(2'd0, 3'd2, 32'h3000_0000);
    cfg(2'd1, 3'd2, mk_attr(1, 10, 1, 0, 1, 0, 1));
    clear_flag();
    access(32'h3000_0010, 2'd2, 1'b0, 1'b0, "R5 fetch from nx");
    access(32'h3000_0010, 2'd0, 1'b0, 1'b0, "R5 read nx ok");
    access(32'h3000_0014, 2'd2, 1'b1, 1'b0, "R5 priv fetch nx");

    // R7 region enable
    cfg(2'd1, 3'd1, mk_attr(0, 12, 1, 1, 1, 1, 0));
    access(32'h2000_1000, 2'd1, 1'b0, 1'b1, "R7 disabled region, clear with new fault");

    // R8 default map
    clear_flag();
    access(32'h4000_0000, 2'd0, 1'b1, 1'b0, "R8 priv miss no default map");
    cfg(2'd2, 3'd0, 32'd3);
    access(32'h4000_0000, 2'd0, 1'b1, 1'b0, "R8 priv miss default map");
    access(32'h4000_0004, 2'd0, 1'b0, 1'b0, "R8 unpriv miss");
    cfg(2'd3, 3'd0, 32'd0);
    access(32'h4000_0008, 2'd0, 1'b1, 1'b0, "R1 kind 3 ignored");

    // R2 size clamp low and high, R1 top index
    clear_flag();
    cfg(2'd0, 3'd3, 32'h5000_0000);
    cfg(2'd1, 3'd3, mk_attr(1, 0, 1, 1, 1, 1, 0));
    access(32'h5000_001F, 2'd1, 1'b0, 1'b0, "R2 clamp 32B inside");
    access(32'h5000_0020, 2'd1, 1'b0, 1'b0, "R2 clamp 32B outside");
    cfg(2'd0, 3'd7, 32'h0);
    cfg(2'd1, 3'd7, mk_attr(1, 63, 0, 0, 1, 0, 0));
    access(32'h9ABC_DEF0, 2'd0, 1'b0, 1'b0, "R1 R2 whole space read");
    access(32'h2000_0000, 2'd1, 1'b1, 1'b0, "R1 R2 R6 whole space write");
    cfg(2'd1, 3'd7, 32'd0);

    // R12 back-pressure
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'hE000_0004; req_type = 2'd0; req_priv = 1'b0;
    @(negedge clk);
    req_addr = 32'hE000_0008; req_priv = 1'b1;
    check("R12 first result", 32'(rsp_code), 32'd2);
    check("R12 ready low", 32'(req_ready), 32'd0);
    @(negedge clk);
    check("R12 held valid", 32'(rsp_valid), 32'd1);
    check("R12 held code", 32'(rsp_code), 32'd2);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 second result", 32'(rsp_code), 32'd0);
    check("R12 second valid", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    check("R12 drained", 32'(rsp_valid), 32'd0);

    // random mix
    for (int it = 0; it < 600; it++) begin
      int sel = int'($urandom % 20);
      if (sel < 3) begin
        logic [2:0] ri = 3'($urandom % NREG);
        if ($urandom % 2) cfg(2'd0, ri, $urandom);
        else cfg(2'd1, ri, mk_attr(($urandom % 4) != 0, int'($urandom % 22) + ((($urandom % 8) == 0) ? 30 : 3),
                                   1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom)));
      end else if (sel == 3) begin
        cfg(2'd2, 3'd0, 32'($urandom % 4));
      end else begin
        logic [31:0] a;
        logic [2:0] ri = 3'($urandom % NREG);
        int k = eff_k(m_attr[ri][6:1]);
        if (k > 24) k = 24;
        if ($urandom % 2) a = (m_base[ri] & ~((32'd1 << k) - 1)) + ($urandom % (32'd2 << k)) - 32'd4;
        else a = $urandom;
        access(a, 2'($urandom % 4), 1'($urandom), (($urandom % 16) == 0), "R2 R4 R5 R6 random");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule